// File: doc/BRIEF.md
# Lockable Mode Command Register

This block sits behind the serial receiver of a three-phase gate pre-driver. Each time the receiver delivers a complete byte, the block looks at the top three bits to find the command. A mode command updates three control flags. The first flag is the lock. The second removes the dead-time interlock between the high and low side of a phase. The third stops the drivers from shutting down when a desaturation or phase fault is detected. A mask command loads one of two 4-bit interrupt mask nibbles. The block also recognises a dead-time write; it stores no dead-time value but treats the byte as a protected register write.

The lock can only be set. A single mode byte may set the lock and the other flags at the same time, and the flags from that byte take effect. After that, the block discards every mode, mask or dead-time write. For each discarded write it raises a one-cycle write-error pulse, in the same cycle as the strobe of the offending byte. Only a device reset releases the lock.

Top module: `modeCmdReg`

## Requirements
- R1: While reset is held and right after it is released, `modeWord` is 0, `maskWord` is 0 and `writeErr` is 0. After reset the dead-time interlock is active and fault shutdown is enabled.
- R2: A byte whose bits 7..5 are `010` (mode command) is taken in while unlocked. Byte bit 0 goes to `modeWord[0]` (lock), bit 1 to `modeWord[1]` (full-on, interlock disabled) and bit 3 to `modeWord[3]` (fault shutdown disabled). The new value is visible after the clock edge that samples the strobe.
- R3: Bits 2 and 4 of a mode byte are ignored, and `modeWord[2]` and `modeWord[4]` always read 0.
- R4: A byte with bits 7..5 = `001` (mask command) is taken in while unlocked and loads byte bits 3..0 into one nibble. Byte bit 4 picks the nibble: 0 selects `maskWord[3:0]`, 1 selects `maskWord[7:4]`. The other nibble keeps its value.
- R5: Once `modeWord[0]` is 1, no byte clears it and the other mode flags keep their values.
- R6: While locked, a mode, mask, or dead-time write (bits 7..5 = `100`) changes no output register. `writeErr` is 1 in the cycle of that strobe and 0 in the next cycle.
- R7: A mode byte with bit 0 set, taken while unlocked, applies its flag bits and the lock together and does not raise `writeErr`.
- R8: Only reset clears the lock. After reset, mode and mask writes are accepted again.
- R9: Bytes with bits 7..5 equal to `000`, `011`, `101`, `110` or `111` change nothing and never raise `writeErr`. The same holds for an unlocked dead-time write.
- R10: `writeErr` is never 1 unless `byteValid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | One-cycle strobe marking a received byte |
| byteData | input | 8 | Received command byte |
| modeWord | output | 5 | Mode flags: bit 0 lock, bit 1 full-on, bit 3 fault-shutdown disable, bits 2 and 4 zero |
| maskWord | output | 8 | Interrupt masks: [3:0] first nibble, [7:4] second nibble |
| writeErr | output | 1 | Pulse flagging a write rejected because of the lock |

## Verification
The properties assume that `byteData` only carries meaning while `byteValid` is high. They also assume that `rstN` is the only way back to the unlocked state. The rejected-write pulse is therefore qualified by the strobe, and a locked state is expected to hold its outputs in every later cycle. The bench respects this in three ways. It changes `byteValid` and `byteData` only on falling edges, one byte per strobe cycle. It drops the strobe between bytes. It uses the reset pin as the only means of unlocking.

// File: rtl/modeCmdPkg.sv
package modeCmdPkg;
  localparam int BYTE_W     = 8;
  localparam int OP_W       = 3;
  localparam int MASK_W     = 4;
  localparam int MASK_COUNT = 2;
  localparam int SEL_W      = (MASK_COUNT > 1) ? $clog2(MASK_COUNT) : 1;
  localparam int HDR_W      = BYTE_W - MASK_W;
  localparam int MODE_W     = 5;
  localparam int LOCK_BIT   = 0;
  localparam int FULLON_BIT = 1;
  localparam int DESAT_BIT  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MASK = 3'b001,
    OP_MODE = 3'b010,
    OP_DEAD = 3'b100
  } cmdOp_e;

  typedef struct packed {
    logic                  modeWe;
    logic [MASK_COUNT-1:0] maskWe;
    logic                  reject;
  } cmdStrobe_t;
endpackage

// File: rtl/modeCmdCtrl.sv
module modeCmdCtrl
  import modeCmdPkg::*;
#(
  parameter int HDR_BITS = HDR_W
) (
  input  logic                byteValid,
  input  logic [HDR_BITS-1:0] header,
  input  logic                lockQ,
  output cmdStrobe_t          strb
);
  localparam int OP_LSB = HDR_BITS - OP_W;

  logic [OP_W-1:0]  opField;
  logic [SEL_W-1:0] selField;
  logic             isMode;
  logic             isMask;
  logic             isDead;

  assign opField  = header[HDR_BITS-1 -: OP_W];
  assign selField = header[SEL_W-1:0];
  assign isMode   = (opField == OP_MODE);
  assign isMask   = (opField == OP_MASK);
  assign isDead   = (opField == OP_DEAD);

  always_comb begin
    strb        = '0;
    strb.modeWe = byteValid && isMode && !lockQ;
    for (int i = 0; i < MASK_COUNT; i++) begin
      strb.maskWe[i] = byteValid && isMask && !lockQ && (selField == i[SEL_W-1:0]);
    end
    strb.reject = byteValid && lockQ && (isMode || isMask || isDead);
  end

  if (OP_LSB < SEL_W) begin : g_badHdr
    initial $error("header too narrow for opcode and select");
  end
endmodule

// File: rtl/modeCmdData.sv
module modeCmdData
  import modeCmdPkg::*;
#(
  parameter int NIB_W   = MASK_W,
  parameter int NIB_CNT = MASK_COUNT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cmdStrobe_t               strb,
  input  logic [NIB_W-1:0]         payload,
  output logic                     lockQ,
  output logic [MODE_W-1:0]        modeWord,
  output logic [NIB_W*NIB_CNT-1:0] maskWord,
  output logic                     writeErr
);
  logic fullOnQ;
  logic desatOffQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ     <= 1'b0;
      fullOnQ   <= 1'b0;
      desatOffQ <= 1'b0;
    end else if (strb.modeWe) begin
      lockQ     <= lockQ | payload[LOCK_BIT];
      fullOnQ   <= payload[FULLON_BIT];
      desatOffQ <= payload[DESAT_BIT];
    end
  end

  always_comb begin
    modeWord             = '0;
    modeWord[LOCK_BIT]   = lockQ;
    modeWord[FULLON_BIT] = fullOnQ;
    modeWord[DESAT_BIT]  = desatOffQ;
  end

  for (genvar n = 0; n < NIB_CNT; n++) begin : g_mask
    logic [NIB_W-1:0] nibQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              nibQ <= '0;
      else if (strb.maskWe[n]) nibQ <= payload;
    end
    assign maskWord[n*NIB_W +: NIB_W] = nibQ;
  end

  assign writeErr = strb.reject;
endmodule

// File: rtl/modeCmdReg.sv
module modeCmdReg
  import modeCmdPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         byteValid,
  input  logic [BYTE_W-1:0]            byteData,
  output logic [MODE_W-1:0]            modeWord,
  output logic [MASK_W*MASK_COUNT-1:0] maskWord,
  output logic                         writeErr
);
  cmdStrobe_t strb;
  logic       lockQ;

  modeCmdCtrl #(.HDR_BITS(HDR_W)) ctrl_i (
    .byteValid (byteValid),
    .header    (byteData[BYTE_W-1:MASK_W]),
    .lockQ     (lockQ),
    .strb      (strb)
  );

  modeCmdData #(.NIB_W(MASK_W), .NIB_CNT(MASK_COUNT)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .payload  (byteData[MASK_W-1:0]),
    .lockQ    (lockQ),
    .modeWord (modeWord),
    .maskWord (maskWord),
    .writeErr (writeErr)
  );
endmodule

// File: rtl/modeCmdReg_chk.sv
module modeCmdReg_chk
  import modeCmdPkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         byteValid,
  input logic [BYTE_W-1:0]            byteData,
  input logic [MODE_W-1:0]            modeWord,
  input logic [MASK_W*MASK_COUNT-1:0] maskWord,
  input logic                         writeErr
);
  p_err_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    writeErr |-> byteValid);

  p_err_only_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    writeErr |-> modeWord[LOCK_BIT]);

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeWord[LOCK_BIT] |=> modeWord[LOCK_BIT]);

  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeWord[LOCK_BIT] |=> ($stable(modeWord) && $stable(maskWord)));

  p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeWord[2] == 1'b0) && (modeWord[4] == 1'b0));

  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteData[7:5] == 3'b010 && !modeWord[LOCK_BIT])
      |=> (modeWord[FULLON_BIT] == $past(byteData[FULLON_BIT]) &&
           modeWord[DESAT_BIT]  == $past(byteData[DESAT_BIT])));

  p_combined_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteData[7:5] == 3'b010 && byteData[0] && !modeWord[LOCK_BIT])
      |-> !writeErr ##1 modeWord[LOCK_BIT]);
endmodule

bind modeCmdReg modeCmdReg_chk chk_i (.*);

// File: tb/modeCmdReg_tb_top.sv
module modeCmdReg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [4:0] modeWord;
  logic [7:0] maskWord;
  logic       writeErr;

  int testCount = 0;
  int failCount = 0;
  logic errSeen;

  always #2 clk = ~clk;

  modeCmdReg dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .modeWord(modeWord), .maskWord(maskWord), .writeErr(writeErr)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    byteValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // drive one byte for one cycle, capture the same-cycle error flag
  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    #1 errSeen = writeErr;
    @(negedge clk);
    byteValid = 1'b0;
    byteData  = 8'h00;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "modeWord in reset", 16'(modeWord), 16'h00);
    check("R1", "maskWord in reset", 16'(maskWord), 16'h00);
    doReset();
    check("R1", "modeWord after reset", 16'(modeWord), 16'h00);
    check("R1", "maskWord after reset", 16'(maskWord), 16'h00);
    check("R1", "writeErr after reset", 16'(writeErr), 16'h0);
  endtask

  task automatic t_modeWrite();
    sendByte(8'h4A);
    check("R2", "mode 4A", 16'(modeWord), 16'h0A);
    check("R2", "no err unlocked", 16'(errSeen), 16'h0);
    sendByte(8'h40);
    check("R2", "mode cleared", 16'(modeWord), 16'h00);
    sendByte(8'h5E);
    check("R3", "bits 2 and 4 ignored", 16'(modeWord), 16'h0A);
  endtask

  task automatic t_maskWrite();
    sendByte(8'h25);
    check("R4", "first nibble", 16'(maskWord), 16'h05);
    sendByte(8'h3C);
    check("R4", "second nibble", 16'(maskWord), 16'hC5);
    sendByte(8'h29);
    check("R4", "first nibble rewrite", 16'(maskWord), 16'hC9);
  endtask

  task automatic t_otherOps();
    logic [7:0] ops [6] = '{8'h80, 8'h00, 8'h6F, 8'hA3, 8'hD1, 8'hFF};
    for (int i = 0; i < 6; i++) begin
      sendByte(ops[i]);
      check("R9", "no err other op", 16'(errSeen), 16'h0);
      check("R9", "mode unchanged", 16'(modeWord), 16'h0A);
      check("R9", "mask unchanged", 16'(maskWord), 16'hC9);
    end
  endtask

  task automatic t_combinedLock();
    sendByte(8'h43);
    check("R7", "mode plus lock applied", 16'(modeWord), 16'h03);
    check("R7", "no err on locking write", 16'(errSeen), 16'h0);
  endtask

  task automatic t_lockedRejects();
    sendByte(8'h48);
    check("R6", "mode write err", 16'(errSeen), 16'h1);
    check("R6", "err one cycle", 16'(writeErr), 16'h0);
    check("R6", "mode held", 16'(modeWord), 16'h03);
    sendByte(8'h40);
    check("R5", "lock not cleared", 16'(modeWord), 16'h03);
    check("R6", "clear attempt err", 16'(errSeen), 16'h1);
    sendByte(8'h2F);
    check("R6", "mask write err", 16'(errSeen), 16'h1);
    check("R6", "mask held", 16'(maskWord), 16'hC9);
    sendByte(8'h91);
    check("R6", "deadtime write err", 16'(errSeen), 16'h1);
    sendByte(8'h00);
    check("R9", "non-write op no err when locked", 16'(errSeen), 16'h0);
    @(negedge clk);
    check("R10", "err idle without strobe", 16'(writeErr), 16'h0);
  endtask

  task automatic t_resetClears();
    doReset();
    check("R8", "lock cleared by reset", 16'(modeWord), 16'h00);
    check("R8", "mask cleared by reset", 16'(maskWord), 16'h00);
    sendByte(8'h2A);
    check("R8", "mask accepted again", 16'(maskWord), 16'h0A);
    check("R8", "no err after reset", 16'(errSeen), 16'h0);
    sendByte(8'h42);
    check("R8", "mode accepted again", 16'(modeWord), 16'h02);
  endtask

  initial begin
    t_reset();
    t_modeWrite();
    t_maskWrite();
    t_otherOps();
    t_combinedLock();
    t_lockedRejects();
    t_resetClears();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #400000;
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule